// File: doc/BRIEF.md
# Luma Sync Insertion and 2x Interpolator

This block forms the luminance path of a digital composite video encoder. It receives 8-bit luma samples at the pixel rate, along with sync and blank flags from an upstream timing generator. It scales each sample by a programmable gain and adds a programmable black-level offset, so that different set-up levels can be produced. The result is limited to the 10-bit output range.

After the gain and offset stage, a sync flag replaces the sample with the sync level. Otherwise, a blank flag replaces it with the blanking level. Both levels are held in 8-bit registers and scaled by four onto the 10-bit output scale. A write port can change either level.

The block runs on the double-rate clock. A pixel enable is high every second cycle. The pixel-rate stream is interpolated by two with a 7-tap half-band filter, so the output carries one 10-bit sample per clock. The levels are inserted ahead of the filter, so the filter also rounds off the sync and blanking edges.

Top module: `luma_sync_interp`

## Requirements
- R1: After reset, `y_out` is 0, the sync level register holds 0 and the blank level register holds 60, which gives 240 on the output scale.
- R2: For an active sample, the pixel value is ((y × gain) >> 5) + 4 × offset. Gain is unsigned with 7 fractional bits, so 128 means unity. Offset is 8-bit two's complement.
- R3: The pixel value is clamped to 0 at the low end and to 1023 at the high end.
- R4: When the sync flag is 1, the pixel value is 4 × sync level, whatever the blank flag and luma are. Sync takes precedence over blank.
- R5: When the blank flag is 1 and the sync flag is 0, the pixel value is 4 × blank level.
- R6: A cycle with `lvl_we`=1 writes `lvl_data` to the blank level when `lvl_sel`=1, and to the sync level when `lvl_sel`=0. Later pixels use the new level.
- R7: The output alternates between two kinds of sample. One is a pixel value s[j], passed through unchanged. The next is clamp((9·(s[j]+s[j+1]) − s[j−1] − s[j+2] + 8) >>> 4), with the shift rounding toward minus infinity.
- R8: Pixel j is captured on the clock edge where `pix_en`=1. Its value s[j] appears on `y_out` after the 7th following clock edge, and the interpolated sample follows one clock later.
- R9: The luma input and both flags are ignored on clocks where `pix_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel enable, high every second cycle |
| y_in | input | 8 | Luma sample |
| sync_in | input | 1 | Sync interval flag |
| blank_in | input | 1 | Blanking interval flag |
| gain | input | 8 | Unsigned gain, 7 fractional bits |
| offset | input | 8 | Signed black-level offset, in input LSBs |
| lvl_we | input | 1 | Level register write strobe |
| lvl_sel | input | 1 | 0 selects the sync level, 1 selects the blank level |
| lvl_data | input | 8 | Level value to write |
| y_out | output | 10 | Interpolated 10-bit luma |

## Verification
The bench builds the block with its default parameters: 8-bit input, 10-bit output, 7 fractional gain bits and 8-bit level registers. At these widths, a gain just below two on full-scale luma pushes past the top of the range, and a negative offset pushes past the bottom. Both clamps of the pixel stage can therefore be reached. Steps between sync, blank and picture levels drive the filter's negative side taps into overshoot, which exercises the clamp on the interpolated samples as well.

// File: rtl/luma_sync_interp.sv
module luma_sync_interp #(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 7,
  parameter int LVL_W     = 8,
  parameter int SYNC_DEF  = 0,
  parameter int BLANK_DEF = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [IN_W-1:0]  y_in,
  input  logic             sync_in,
  input  logic             blank_in,
  input  logic [GAIN_W-1:0] gain,
  input  logic [IN_W-1:0]  offset,
  input  logic             lvl_we,
  input  logic             lvl_sel,
  input  logic [LVL_W-1:0] lvl_data,
  output logic [OUT_W-1:0] y_out
);
  localparam int UP   = OUT_W - IN_W;
  localparam int SH   = GAIN_FRAC - UP;
  localparam int LSH  = OUT_W - LVL_W;
  localparam int PW   = IN_W + GAIN_W;
  localparam int CW   = PW + 2;
  localparam logic signed [CW-1:0] MAXS = CW'((1 << OUT_W) - 1);
  localparam logic signed [CW-1:0] K9   = CW'(9);
  localparam logic signed [CW-1:0] KRND = CW'(8);

  logic [IN_W-1:0]  y1;
  logic             sy1, bk1;
  logic [LVL_W-1:0] sync_lvl, blank_lvl;
  logic [OUT_W-1:0] p0, p1, p2, p3, pre;
  logic [PW-1:0]    prod;
  logic signed [CW-1:0] pix_v, mid_v, e0, e1, e2, e3;

  function automatic logic [OUT_W-1:0] clip(input logic signed [CW-1:0] v);
    if (v < 0)         return '0;
    else if (v > MAXS) return MAXS[OUT_W-1:0];
    else               return v[OUT_W-1:0];
  endfunction

  assign prod  = PW'(y1) * PW'(gain);
  assign pix_v = $signed(CW'(prod >> SH)) + (CW'($signed(offset)) <<< UP);
  assign pre   = sy1 ? (OUT_W'(sync_lvl) << LSH)
               : bk1 ? (OUT_W'(blank_lvl) << LSH)
               : clip(pix_v);

  assign e0 = $signed(CW'(p0));
  assign e1 = $signed(CW'(p1));
  assign e2 = $signed(CW'(p2));
  assign e3 = $signed(CW'(p3));
  assign mid_v = (K9 * (e1 + e2) - e0 - e3 + KRND) >>> 4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y1 <= '0; sy1 <= 1'b0; bk1 <= 1'b0;
      p0 <= '0; p1 <= '0; p2 <= '0; p3 <= '0;
      y_out <= '0;
      sync_lvl  <= LVL_W'(SYNC_DEF);
      blank_lvl <= LVL_W'(BLANK_DEF);
    end else begin
      if (lvl_we) begin
        if (lvl_sel) blank_lvl <= lvl_data;
        else         sync_lvl  <= lvl_data;
      end
      if (pix_en) begin
        y1 <= y_in; sy1 <= sync_in; bk1 <= blank_in;
        p0 <= pre; p1 <= p0; p2 <= p1; p3 <= p2;
        y_out <= clip(mid_v);
      end else begin
        y_out <= p2;
      end
    end
  end

  // R4
  sync_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && sy1 |=> p0 == (OUT_W'($past(sync_lvl)) << LSH));

  // R5
  blank_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && bk1 && !sy1 |=> p0 == (OUT_W'($past(blank_lvl)) << LSH));

  // R6
  lvl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we && lvl_sel |=> blank_lvl == $past(lvl_data));

  // R7
  dc_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && p0 == p1 && p1 == p2 && p2 == p3 |=> y_out == $past(p1));

  // R8
  pass_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> y_out == $past(p0, 4));
endmodule

// File: tb/luma_sync_interp_tb_top.sv
module luma_sync_interp_tb_top;
  logic clk = 1'b0;
  logic rst_n, pix_en, sync_in, blank_in, lvl_we, lvl_sel;
  logic [7:0] y_in, gain, offset, lvl_data;
  logic [9:0] y_out;

  always #2 clk = ~clk;

  luma_sync_interp dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .y_in(y_in),
    .sync_in(sync_in), .blank_in(blank_in), .gain(gain), .offset(offset),
    .lvl_we(lvl_we), .lvl_sel(lvl_sel), .lvl_data(lvl_data), .y_out(y_out));

  typedef struct { int v; string r; } exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0;
  int lat = 0;
  bit run = 0, done = 0;
  int m_gain = 128, m_off = 0, m_sync = 0, m_blank = 60;
  int ya[32], sa[32], ba[32];
  string s_tag;

  task automatic chk(int act, int exp, string r);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  function automatic int clampv(int v);
    return v < 0 ? 0 : (v > 1023 ? 1023 : v);
  endfunction

  function automatic int fpix(int y, int s, int b);
    if (s != 0) return m_sync * 4;
    if (b != 0) return m_blank * 4;
    return clampv(((y * m_gain) >>> 5) + m_off * 4);
  endfunction

  function automatic int fmid(int a, int b, int c, int d);
    return clampv((9 * (b + c) - a - d + 8) >>> 4);
  endfunction

  initial forever begin
    @(posedge clk); #1;
    if (run) begin
      if (lat > 0) lat--;
      else if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(int'(y_out), e.v, e.r);
        if (q.size() == 0) run = 0;
      end
    end
  end

  task automatic pix(int y, int s, int b);
    @(negedge clk);
    pix_en = 1; y_in = 8'(y); sync_in = s[0]; blank_in = b[0];
    @(negedge clk);
    pix_en = 0; lvl_we = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) pix(0, 0, 0);
  endtask

  task automatic set_cfg(int g, int o);
    m_gain = g; m_off = o;
    gain = 8'(g); offset = 8'(o);
    idle(6);
  endtask

  task automatic wr_lvl(int sel, int d);
    @(negedge clk);
    pix_en = 1; y_in = 0; sync_in = 0; blank_in = 0;
    lvl_we = 1; lvl_sel = sel[0]; lvl_data = 8'(d);
    if (sel != 0) m_blank = d; else m_sync = d;
    @(negedge clk);
    pix_en = 0; lvl_we = 0;
  endtask

  task automatic stream(int n);
    int s[34];
    exp_t e;
    s[0] = fpix(0, 0, 0);
    for (int j = 0; j < n; j++) s[j+1] = fpix(ya[j], sa[j], ba[j]);
    for (int j = 0; j + 2 < n; j++) begin
      e.v = s[j+1]; e.r = (j == 0) ? "R8" : s_tag; q.push_back(e);
      e.v = fmid(s[j], s[j+1], s[j+2], s[j+3]); e.r = "R7"; q.push_back(e);
    end
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      pix_en = 1; y_in = 8'(ya[j]); sync_in = sa[j][0]; blank_in = ba[j][0];
      if (j == 0) begin lat = 7; run = 1; end
      @(negedge clk);
      // R9: garbage on disabled cycles
      pix_en = 0; y_in = 8'(8'hA5 ^ j); sync_in = 1; blank_in = 1;
    end
    while (run) pix(0, 0, 0);
    idle(6);
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    finish_up();
  end

  initial begin
    rst_n = 0; pix_en = 0; y_in = 0; sync_in = 0; blank_in = 0;
    lvl_we = 0; lvl_sel = 0; lvl_data = 0; gain = 8'd128; offset = 0;
    idle(3);
    rst_n = 1;
    chk(int'(y_out), 0, "R1");
    idle(4);
    chk(int'(y_out), 0, "R1");

    // R2: gain 0.75, offset +10, varied luma
    set_cfg(96, 10);
    s_tag = "R2";
    for (int j = 0; j < 10; j++) begin ya[j] = (j * 53 + 17) % 256; sa[j] = 0; ba[j] = 0; end
    stream(10);

    // R3: high clamp with gain near 2
    set_cfg(255, 0);
    s_tag = "R3";
    for (int j = 0; j < 8; j++) begin ya[j] = (j % 2 == 0) ? 255 : 10; sa[j] = 0; ba[j] = 0; end
    stream(8);

    // R3: low clamp with negative offset
    set_cfg(128, -100);
    for (int j = 0; j < 8; j++) begin ya[j] = j * 30; sa[j] = 0; ba[j] = 0; end
    stream(8);

    // R1, R4, R5: default levels, sync over blank
    set_cfg(128, 0);
    s_tag = "R5";
    for (int j = 0; j < 12; j++) begin
      ya[j] = 200; sa[j] = (j >= 3 && j < 6) ? 1 : 0; ba[j] = (j >= 2 && j < 9) ? 1 : 0;
    end
    stream(12);
    s_tag = "R4";
    for (int j = 0; j < 6; j++) begin ya[j] = 255; sa[j] = 1; ba[j] = j % 2; end
    stream(6);

    // R6: rewrite both levels
    wr_lvl(0, 16);
    wr_lvl(1, 50);
    idle(2);
    s_tag = "R6";
    for (int j = 0; j < 12; j++) begin
      ya[j] = 128; sa[j] = (j >= 4 && j < 7) ? 1 : 0; ba[j] = (j >= 2 && j < 9) ? 1 : 0;
    end
    stream(12);

    finish_up();
  end
endmodule